// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a synchronous vending controller that takes at most one coin per clock cycle. The coin can be a nickel, a dime or a quarter, and each arrives as its own strobe. The controller keeps the running credit in 5-cent units. When a coin brings the total to 30 cents or more, the controller asserts the dispense output in that same cycle and clears the credit. It also signals change in that same cycle: a dime, a nickel, or both.

The outputs are Mealy outputs. They are formed from the present credit and the coin that is arriving, so they fall in the cycle of the final coin and not one clock later. Change is limited to one dime and one nickel. Any overpayment beyond 15 cents therefore returns only those two coins, and the rest is kept. A cycle with more than one coin strobe high is treated as invalid and has no effect.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the credit to 0. A quarter inserted right after reset therefore does not dispense.
- R2: A single nickel, dime or quarter strobe adds 5, 10 or 25 cents to the credit.
- R3: `vend` is 1 in the cycle where the strobed coin brings the total to 30 cents or more. It is 0 in every other cycle.
- R4: After a dispensing cycle the credit is 0, so the next dispense needs a full 30 cents.
- R5: The overpayment is total minus 30 cents. 5 cents gives `changeNickel`. 10 cents gives `changeDime`. 15 cents or more gives both, and any amount above 15 cents is kept.
- R6: A cycle with two or three coin strobes high leaves the credit unchanged and drives all outputs to 0.
- R7: With no coin strobe high, all outputs are 0 and the credit holds its value.
- R8: A total of exactly 30 cents dispenses with neither change output set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coinNickel | input | 1 | A nickel is inserted this cycle |
| coinDime | input | 1 | A dime is inserted this cycle |
| coinQuarter | input | 1 | A quarter is inserted this cycle |
| vend | output | 1 | Dispense merchandise (Mealy) |
| changeDime | output | 1 | Return a dime (Mealy) |
| changeNickel | output | 1 | Return a nickel (Mealy) |

## Verification
The assertions assume that the coin strobes are clean, synchronous single-cycle levels, and that `rst` is held high across at least one rising edge before any coin arrives. They make no assumption that strobes are one-hot: a cycle with several strobes high is legal input and is checked to be ignored. The stimulus changes inputs only on the falling clock edge and samples the Mealy outputs halfway through the low phase. It drives every combination of valid coins, overlapping strobes and idle gaps, so the credit never runs outside its six legal values.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Strobes from the control path to the credit datapath.
  typedef struct packed {
    logic loadCredit;   // capture the new running sum
    logic clearCredit;  // return credit to zero after a dispense
  } dpStrobes_t;

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath #(
  parameter int CREDIT_W = 3,
  parameter int SUM_W    = 4,
  parameter int PRICE_U  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  vend_pkg::dpStrobes_t  strobes,
  input  logic [SUM_W-1:0]      addend,
  output logic [CREDIT_W-1:0]   credit,
  output logic [SUM_W-1:0]      sum
);

  logic [CREDIT_W-1:0] creditQ;

  assign sum    = SUM_W'(creditQ) + addend;
  assign credit = creditQ;

  always_ff @(posedge clk) begin
    if (rst || strobes.clearCredit) creditQ <= '0;
    else if (strobes.loadCredit)    creditQ <= CREDIT_W'(sum);
  end

  // Credit always stays below the price (R2, R4)
  p_credit_range_r2: assert property (@(posedge clk) disable iff (rst)
    (SUM_W'(creditQ) < SUM_W'(PRICE_U)));

  // Both strobes must never be raised together
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadCredit && strobes.clearCredit));

endmodule

// File: rtl/vend_control.sv
module vend_control #(
  parameter int CREDIT_W  = 3,
  parameter int SUM_W     = 4,
  parameter int NICKEL_U  = 1,
  parameter int DIME_U    = 2,
  parameter int QUARTER_U = 5,
  parameter int PRICE_U   = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  coinNickel,
  input  logic                  coinDime,
  input  logic                  coinQuarter,
  input  logic [SUM_W-1:0]      sum,
  output logic [SUM_W-1:0]      addend,
  output vend_pkg::dpStrobes_t  strobes,
  output logic                  vend,
  output logic                  changeDime,
  output logic                  changeNickel
);

  logic [2:0]       coinVec;
  logic             oneCoin;
  logic             reached;
  logic [SUM_W-1:0] overpay;
  logic [SUM_W-1:0] afterDime;

  assign coinVec = {coinQuarter, coinDime, coinNickel};
  assign oneCoin = (coinVec == 3'b001) || (coinVec == 3'b010) || (coinVec == 3'b100);

  always_comb begin
    addend = '0;
    if (oneCoin) begin
      unique case (coinVec)
        3'b001:  addend = SUM_W'(NICKEL_U);
        3'b010:  addend = SUM_W'(DIME_U);
        default: addend = SUM_W'(QUARTER_U);
      endcase
    end
  end

  assign reached = oneCoin && (sum >= SUM_W'(PRICE_U));
  assign overpay = reached ? sum - SUM_W'(PRICE_U) : '0;

  always_comb begin
    changeDime   = overpay >= SUM_W'(DIME_U);
    afterDime    = changeDime ? overpay - SUM_W'(DIME_U) : overpay;
    changeNickel = afterDime >= SUM_W'(NICKEL_U);
  end

  assign vend                = reached;
  assign strobes.clearCredit = reached;
  assign strobes.loadCredit  = oneCoin && !reached;

  // Change is only ever returned alongside a dispense (R5)
  p_change_with_vend_r5: assert property (@(posedge clk) disable iff (rst)
    (changeDime || changeNickel) |-> vend);

  // Overlapping strobes produce no output (R6)
  p_multi_silent_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(coinVec) > 1) |-> !(vend || changeDime || changeNickel));

  // Idle cycle produces no output (R7)
  p_idle_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (coinVec == 3'b000) |-> !(vend || changeDime || changeNickel));

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl #(
  parameter int NICKEL_U  = 1,
  parameter int DIME_U    = 2,
  parameter int QUARTER_U = 5,
  parameter int PRICE_U   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic coinNickel,
  input  logic coinDime,
  input  logic coinQuarter,
  output logic vend,
  output logic changeDime,
  output logic changeNickel
);

  localparam int CREDIT_W = $clog2(PRICE_U);
  localparam int SUM_W    = $clog2(PRICE_U + QUARTER_U);

  vend_pkg::dpStrobes_t strobes;
  logic [SUM_W-1:0]     addend;
  logic [SUM_W-1:0]     sum;
  logic [CREDIT_W-1:0]  credit;

  vend_control #(
    .CREDIT_W(CREDIT_W), .SUM_W(SUM_W), .NICKEL_U(NICKEL_U),
    .DIME_U(DIME_U), .QUARTER_U(QUARTER_U), .PRICE_U(PRICE_U)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .coinNickel(coinNickel), .coinDime(coinDime), .coinQuarter(coinQuarter),
    .sum(sum), .addend(addend), .strobes(strobes),
    .vend(vend), .changeDime(changeDime), .changeNickel(changeNickel)
  );

  vend_datapath #(
    .CREDIT_W(CREDIT_W), .SUM_W(SUM_W), .PRICE_U(PRICE_U)
  ) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .addend(addend),
    .credit(credit), .sum(sum)
  );

  // Credit is zero in the cycle after a dispense (R4)
  p_vend_clears_r4: assert property (@(posedge clk) disable iff (rst)
    vend |=> (credit == '0));

  // Overlapping strobes leave the credit alone (R6)
  p_multi_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (32'(coinNickel) + 32'(coinDime) + 32'(coinQuarter) > 1) |=> $stable(credit));

  // No strobe: credit holds (R7)
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !(coinNickel || coinDime || coinQuarter) |=> $stable(credit));

endmodule

// File: tb/coin_vend_ctrl_tb.sv
module coin_vend_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coinNickel = 1'b0, coinDime = 1'b0, coinQuarter = 1'b0;
  logic vend, changeDime, changeNickel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  coin_vend_ctrl dut_i (
    .clk(clk), .rst(rst),
    .coinNickel(coinNickel), .coinDime(coinDime), .coinQuarter(coinQuarter),
    .vend(vend), .changeDime(changeDime), .changeNickel(changeNickel)
  );

  // coins as "NDQ" bits; expected outputs {vend, changeDime, changeNickel}
  task automatic step(input logic [2:0] ndq, input logic [2:0] exp, input string tag);
    @(negedge clk);
    {coinNickel, coinDime, coinQuarter} = ndq;
    #5;
    checks++;
    if ({vend, changeDime, changeNickel} !== exp) begin
      fails++;
      $display("FAIL %s: coins=%b got vend/dime/nickel=%b expected %b", tag, ndq, {vend, changeDime, changeNickel}, exp);
    end
    @(posedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; {coinNickel, coinDime, coinQuarter} = 3'b000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  localparam logic [2:0] N = 3'b100, D = 3'b010, Q = 3'b001, IDLE = 3'b000;
  localparam logic [2:0] NONE = 3'b000, V = 3'b100, VD = 3'b110, VN = 3'b101, VDN = 3'b111;

  task automatic testReset();
    doReset();
    step(IDLE, NONE, "R1 idle after reset");
    step(Q, NONE, "R1 quarter from zero");
    step(N, V, "R8 exact 30");
    step(Q, NONE, "R1 quarter again");
    doReset();
    step(N, NONE, "R1 credit cleared mid-purchase");
    step(Q, V, "R1 nickel+quarter exact");
  endtask

  task automatic testNickels();
    doReset();
    for (int i = 0; i < 5; i++) step(N, NONE, "R2 nickel accumulates");
    step(N, V, "R2 sixth nickel vends");
  endtask

  task automatic testDimes();
    doReset();
    step(D, NONE, "R2 dime 10");
    step(D, NONE, "R2 dime 20");
    step(D, V, "R3 third dime vends same cycle");
    step(IDLE, NONE, "R3 no vend after");
  endtask

  task automatic testChange();
    doReset();
    step(D, NONE, "R5 setup 10");
    step(Q, VN, "R5 35 gives nickel");
    step(N, NONE, "R5 setup 5");
    step(D, NONE, "R5 setup 15");
    step(Q, VD, "R5 40 gives dime");
    step(D, NONE, "R5 setup 10");
    step(D, NONE, "R5 setup 20");
    step(Q, VDN, "R5 45 gives both");
    step(Q, NONE, "R5 setup 25");
    step(Q, VDN, "R5 50 gives both, rest kept");
  endtask

  task automatic testClearAfterVend();
    doReset();
    step(Q, NONE, "R4 setup 25");
    step(Q, VDN, "R4 vend");
    step(Q, NONE, "R4 credit restarted at 0");
    step(N, V, "R4 exact after restart");
  endtask

  task automatic testMulti();
    doReset();
    step(Q, NONE, "R6 setup 25");
    step(3'b110, NONE, "R6 nickel+dime ignored");
    step(3'b111, NONE, "R6 all three ignored");
    step(3'b101, NONE, "R6 nickel+quarter ignored");
    step(N, V, "R6 credit held at 25");
  endtask

  task automatic testIdle();
    doReset();
    step(D, NONE, "R7 setup 10");
    step(D, NONE, "R7 setup 20");
    for (int i = 0; i < 4; i++) step(IDLE, NONE, "R7 idle silent");
    step(D, V, "R7 credit held at 20");
  endtask

  initial begin
    testReset();
    testNickels();
    testDimes();
    testChange();
    testClearAfterVend();
    testMulti();
    testIdle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule